// File: doc/BRIEF.md
# Timer Control and Status Register Bank

This block keeps the two configuration and status words that sit between a processor's timer counters and its interrupt controller. A 32-bit control word is loaded whole by software and holds the interrupt enables and period selections for three timers: a decrementer, a watchdog and a fixed-interval timer. A status word collects event flags raised by hardware pulses from those counters. Software clears the flags by writing ones to the matching positions.

Each timer drives a level-sensitive interrupt line. The line is high while the timer's status flag and its enable are both set, and it is registered, so it follows a change one cycle later. Whenever software clears an interval timer's flag, or rewrites the control word, the block emits a single-cycle re-arm strobe to that timer's counter. A resume pulse, sent when the processor restarts after a halt, wipes the watchdog flags so that a stale expiry is not acted on.

Top module: `tmr_ctl_stat_regs`

## Requirements
- R1: On a clock edge with rst_n low, the control word, the status word, all three interrupt outputs and both re-arm strobes become 0.
- R2: A cycle with ctl_wr_en high loads all 32 bits of ctl_wr_data into the control word, visible on ctl_q after that edge.
- R3: A cycle with stat_clr_en high clears each status bit whose position in stat_clr_data is 1 and leaves every other bit unchanged. Only bits 31:26 are implemented, and bits 25:0 of stat_q always read 0.
- R4: Hardware event pulses set status bits: evt_fit sets bit 26, evt_dec sets bit 27, evt_wdg_rst ORs into bits 29:28, evt_wdg_int sets bit 30 and evt_wdg_enw sets bit 31.
- R5: When a set event and a clear (by write or by resume) hit the same bit in the same cycle, the bit ends up set.
- R6: irq_dec follows status bit 27 AND control bit 26, irq_wdg follows status bit 30 AND control bit 27, and irq_fit follows status bit 26 AND control bit 23. Each output is registered, so it reflects the status and control values one cycle earlier.
- R7: A resume pulse clears status bits 31:28 and leaves bits 27:26 unchanged.
- R8: rearm_fit is high for exactly the one cycle after a status clear write with bit 26 of stat_clr_data set, whatever the bit's previous value.
- R9: rearm_wdg is high for exactly the one cycle after a status clear write with bit 30 of stat_clr_data set, or after a resume pulse.
- R10: A control write drives both rearm_fit and rearm_wdg high for the one cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_en | input | 1 | Load the control word this cycle |
| ctl_wr_data | input | 32 | New control word |
| stat_clr_en | input | 1 | Apply a write-one-to-clear to the status word |
| stat_clr_data | input | 32 | Mask of status bits to clear |
| resume | input | 1 | Processor resume pulse; clears the watchdog flags |
| evt_dec | input | 1 | Decrementer expiry pulse |
| evt_fit | input | 1 | Fixed-interval expiry pulse |
| evt_wdg_int | input | 1 | Watchdog interrupt event pulse |
| evt_wdg_enw | input | 1 | Watchdog first-stage event pulse |
| evt_wdg_rst | input | 2 | Watchdog reset-status bits to set |
| ctl_q | output | 32 | Current control word |
| stat_q | output | 32 | Current status word |
| irq_dec | output | 1 | Decrementer interrupt |
| irq_wdg | output | 1 | Watchdog interrupt |
| irq_fit | output | 1 | Fixed-interval interrupt |
| rearm_fit | output | 1 | Re-arm strobe to the fixed-interval counter |
| rearm_wdg | output | 1 | Re-arm strobe to the watchdog counter |

## Verification
The hardest cases to reach are the collisions: a hardware event landing in the same cycle as a software clear or a resume that targets the same bit, and a clear write of a bit that is already 0, which must still re-arm its timer. The bench drives these on purpose. It raises evt_wdg_int together with a clear of bit 30, and evt_wdg_enw together with a resume. It issues a fixed-interval clear after the flag is already gone. It then compares every output of each cycle against a model built from the requirements.

// File: rtl/tmr_regs_pkg.sv
// Shared constants for the timer control/status register bank.
// Assumes a 32-bit word; bit positions are fixed because the
// counters and interrupt logic decode these fields.
package tmr_regs_pkg;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned IRQ_N    = 3;
    // control word enable positions
    localparam int unsigned C_WDG_IE = 27;
    localparam int unsigned C_DEC_IE = 26;
    localparam int unsigned C_FIT_IE = 23;
    // status word positions
    localparam int unsigned S_ENW    = 31;
    localparam int unsigned S_WIS    = 30;
    localparam int unsigned S_WRS_HI = 29;
    localparam int unsigned S_WRS_LO = 28;
    localparam int unsigned S_DIS    = 27;
    localparam int unsigned S_FIS    = 26;
    localparam logic [REG_W-1:0] S_IMPL_MASK   = 32'hFC00_0000;
    localparam logic [REG_W-1:0] S_RESUME_MASK = 32'hF000_0000;

    // interrupt lane order: 0 = decrementer, 1 = watchdog, 2 = fixed-interval
    function automatic int unsigned lane_stat_bit(input int unsigned lane);
        case (lane)
            0:       return S_DIS;
            1:       return S_WIS;
            default: return S_FIS;
        endcase
    endfunction

    function automatic int unsigned lane_en_bit(input int unsigned lane);
        case (lane)
            0:       return C_DEC_IE;
            1:       return C_WDG_IE;
            default: return C_FIT_IE;
        endcase
    endfunction
endpackage

// File: rtl/tmr_ctl_reg.sv
// Control word register. Loaded whole on a write strobe.
// Assumes: synchronous active-low reset clears it to zero.
module tmr_ctl_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] ctl_q
);
    // Hold or load the control word.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctl_q <= '0;
        else if (wr_en) ctl_q <= wr_data;
    end
endmodule

// File: rtl/tmr_stat_reg.sv
// Status word register with write-one-to-clear, resume clear and
// hardware set. Set beats clear in the same cycle. Bits outside
// IMPL_MASK are held at zero.
module tmr_stat_reg #(
    parameter int unsigned       W           = 32,
    parameter logic [W-1:0]      IMPL_MASK   = '1,
    parameter logic [W-1:0]      RESUME_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [W-1:0] clr_data,
    input  logic         resume,
    input  logic [W-1:0] set_vec,
    output logic [W-1:0] stat_q
);
    logic [W-1:0] clr_mask;
    logic [W-1:0] stat_nxt;

    // Combine software and resume clears, then apply sets on top.
    always_comb begin
        clr_mask = (clr_en ? clr_data : '0) | (resume ? RESUME_MASK : '0);
        stat_nxt = ((stat_q & ~clr_mask) | set_vec) & IMPL_MASK;
    end

    // Register the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_nxt;
    end
endmodule

// File: rtl/tmr_irq_gen.sv
// Registered interrupt lines: each lane is its status bit AND its
// enable bit, one cycle behind the register values.
module tmr_irq_gen
    import tmr_regs_pkg::*;
#(
    parameter int unsigned W     = REG_W,
    parameter int unsigned LANES = IRQ_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     stat_q,
    input  logic [W-1:0]     ctl_q,
    output logic [LANES-1:0] irq_q
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int unsigned SB = lane_stat_bit(i);
        localparam int unsigned EB = lane_en_bit(i);
        // Register this lane's status-and-enable product.
        always_ff @(posedge clk) begin
            if (!rst_n) irq_q[i] <= 1'b0;
            else        irq_q[i] <= stat_q[SB] & ctl_q[EB];
        end
    end
endmodule

// File: rtl/tmr_rearm_gen.sv
// Single-cycle re-arm strobes to the interval counters, issued the
// cycle after a clear of their flag, a control write or (watchdog) a resume.
module tmr_rearm_gen
    import tmr_regs_pkg::*;
#(
    parameter int unsigned W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctl_wr_en,
    input  logic         clr_en,
    input  logic [W-1:0] clr_data,
    input  logic         resume,
    output logic         rearm_fit,
    output logic         rearm_wdg
);
    // Register the two strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rearm_fit <= 1'b0;
            rearm_wdg <= 1'b0;
        end else begin
            rearm_fit <= ctl_wr_en | (clr_en & clr_data[S_FIS]);
            rearm_wdg <= ctl_wr_en | (clr_en & clr_data[S_WIS]) | resume;
        end
    end
endmodule

// File: rtl/tmr_ctl_stat_regs.sv
// Top: timer control/status register bank. Holds the control word
// and status word, drives three registered interrupt lines and two
// re-arm strobes. Counting and watchdog reset actions live elsewhere.
module tmr_ctl_stat_regs
    import tmr_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr_en,
    input  logic [31:0] ctl_wr_data,
    input  logic        stat_clr_en,
    input  logic [31:0] stat_clr_data,
    input  logic        resume,
    input  logic        evt_dec,
    input  logic        evt_fit,
    input  logic        evt_wdg_int,
    input  logic        evt_wdg_enw,
    input  logic [1:0]  evt_wdg_rst,
    output logic [31:0] ctl_q,
    output logic [31:0] stat_q,
    output logic        irq_dec,
    output logic        irq_wdg,
    output logic        irq_fit,
    output logic        rearm_fit,
    output logic        rearm_wdg
);
    logic [REG_W-1:0] set_vec;
    logic [IRQ_N-1:0] irq_q;

    // Place the hardware event pulses at their status positions.
    always_comb begin
        set_vec           = '0;
        set_vec[S_FIS]    = evt_fit;
        set_vec[S_DIS]    = evt_dec;
        set_vec[S_WRS_LO] = evt_wdg_rst[0];
        set_vec[S_WRS_HI] = evt_wdg_rst[1];
        set_vec[S_WIS]    = evt_wdg_int;
        set_vec[S_ENW]    = evt_wdg_enw;
    end

    tmr_ctl_reg #(.W(REG_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en),
        .wr_data(ctl_wr_data), .ctl_q(ctl_q)
    );

    tmr_stat_reg #(.W(REG_W), .IMPL_MASK(S_IMPL_MASK),
                   .RESUME_MASK(S_RESUME_MASK)) u_stat (
        .clk(clk), .rst_n(rst_n), .clr_en(stat_clr_en),
        .clr_data(stat_clr_data), .resume(resume),
        .set_vec(set_vec), .stat_q(stat_q)
    );

    tmr_irq_gen #(.W(REG_W), .LANES(IRQ_N)) u_irq (
        .clk(clk), .rst_n(rst_n), .stat_q(stat_q),
        .ctl_q(ctl_q), .irq_q(irq_q)
    );

    tmr_rearm_gen #(.W(REG_W)) u_rearm (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en),
        .clr_en(stat_clr_en), .clr_data(stat_clr_data), .resume(resume),
        .rearm_fit(rearm_fit), .rearm_wdg(rearm_wdg)
    );

    assign irq_dec = irq_q[0];
    assign irq_wdg = irq_q[1];
    assign irq_fit = irq_q[2];
endmodule

// File: rtl/tmr_ctl_stat_regs_chk.sv
// Checker for the register bank, bound to the top module.
module tmr_ctl_stat_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_wr_en,
    input logic [31:0] ctl_wr_data,
    input logic        stat_clr_en,
    input logic [31:0] stat_clr_data,
    input logic        resume,
    input logic        evt_fit,
    input logic        evt_wdg_int,
    input logic [31:0] ctl_q,
    input logic [31:0] stat_q,
    input logic        irq_dec,
    input logic        irq_wdg,
    input logic        irq_fit,
    input logic        rearm_fit,
    input logic        rearm_wdg
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (ctl_q == 32'h0 && stat_q == 32'h0 && !irq_dec && !rearm_wdg));
    a_r2_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_en |=> ctl_q == $past(ctl_wr_data));
    a_r3_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[25:0] == 26'h0);
    a_r4_fit_set: assert property (@(posedge clk) disable iff (!rst_n)
        evt_fit |=> stat_q[26]);
    a_r5_wdg_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wdg_int && stat_clr_en && stat_clr_data[30] |=> stat_q[30]);
    a_r6_irq_wdg: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wdg |-> $past(stat_q[30] && ctl_q[27]));
    a_r7_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
        resume && !evt_wdg_int |=> !stat_q[30]);
    a_r8_fit_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr_en && stat_clr_data[26] |=> rearm_fit);
    a_r9_resume_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> rearm_wdg);
    a_r10_ctl_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_en |=> rearm_fit && rearm_wdg);
endmodule

bind tmr_ctl_stat_regs tmr_ctl_stat_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .stat_clr_en(stat_clr_en), .stat_clr_data(stat_clr_data), .resume(resume),
    .evt_fit(evt_fit), .evt_wdg_int(evt_wdg_int), .ctl_q(ctl_q), .stat_q(stat_q),
    .irq_dec(irq_dec), .irq_wdg(irq_wdg), .irq_fit(irq_fit),
    .rearm_fit(rearm_fit), .rearm_wdg(rearm_wdg)
);

// File: tb/tmr_ctl_stat_regs_test.sv
// Scoreboard bench: the driver computes expected outputs from the
// requirements and queues them; the monitor compares after each edge.
module tmr_ctl_stat_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [31:0] ctl_wr_data = '0;
    logic        stat_clr_en = 1'b0;
    logic [31:0] stat_clr_data = '0;
    logic        resume = 1'b0;
    logic        evt_dec = 1'b0, evt_fit = 1'b0, evt_wdg_int = 1'b0, evt_wdg_enw = 1'b0;
    logic [1:0]  evt_wdg_rst = '0;
    logic [31:0] ctl_q, stat_q;
    logic        irq_dec, irq_wdg, irq_fit, rearm_fit, rearm_wdg;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        logic [68:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    // model state
    logic [31:0] m_ctl = '0, m_stat = '0;
    logic        m_id = 0, m_iw = 0, m_if = 0, m_rf = 0, m_rw = 0;

    always #2.5 clk = ~clk;

    tmr_ctl_stat_regs uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .stat_clr_en(stat_clr_en), .stat_clr_data(stat_clr_data), .resume(resume),
        .evt_dec(evt_dec), .evt_fit(evt_fit), .evt_wdg_int(evt_wdg_int),
        .evt_wdg_enw(evt_wdg_enw), .evt_wdg_rst(evt_wdg_rst),
        .ctl_q(ctl_q), .stat_q(stat_q), .irq_dec(irq_dec), .irq_wdg(irq_wdg),
        .irq_fit(irq_fit), .rearm_fit(rearm_fit), .rearm_wdg(rearm_wdg)
    );

    // Driver: apply one cycle of stimulus, advance the model, queue expectation.
    task automatic step(input string tag, input logic rst,
                        input logic cw, input logic [31:0] cd,
                        input logic ce, input logic [31:0] cm,
                        input logic rs, input logic [5:0] ev);
        logic [31:0] setv, clrv, n_stat;
        item_t it;
        @(negedge clk);
        rst_n = !rst; ctl_wr_en = cw; ctl_wr_data = cd;
        stat_clr_en = ce; stat_clr_data = cm; resume = rs;
        {evt_wdg_enw, evt_wdg_int, evt_wdg_rst, evt_dec, evt_fit} = ev;
        @(posedge clk);
        if (rst) begin
            m_ctl = '0; m_stat = '0; {m_id, m_iw, m_if, m_rf, m_rw} = '0;
        end else begin
            setv = {ev, 26'h0};
            clrv = (ce ? cm : 32'h0) | (rs ? 32'hF000_0000 : 32'h0);
            n_stat = ((m_stat & ~clrv) | setv) & 32'hFC00_0000;
            m_id = m_stat[27] & m_ctl[26];
            m_iw = m_stat[30] & m_ctl[27];
            m_if = m_stat[26] & m_ctl[23];
            m_rf = cw | (ce & cm[26]);
            m_rw = cw | (ce & cm[30]) | rs;
            m_stat = n_stat;
            if (cw) m_ctl = cd;
        end
        it.exp = {m_ctl, m_stat, m_id, m_iw, m_if, m_rf, m_rw};
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 32'h0, 0, 32'h0, 0, 6'h0);
    endtask

    // Monitor: compare queued expectations shortly after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [68:0] act;
                it = sb.pop_front();
                act = {ctl_q, stat_q, irq_dec, irq_wdg, irq_fit, rearm_fit, rearm_wdg};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog on the bench itself.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step("R1", 1, 0, 0, 0, 0, 0, 0);
        step("R1", 1, 0, 0, 0, 0, 0, 0);
        // R2: whole-word control write
        step("R2", 0, 1, 32'hA5C3_0F96, 0, 0, 0, 0);
        idle("R2");
        // R10: control write with enables dec/wdg/fit on
        step("R10", 0, 1, 32'h0C80_0000, 0, 0, 0, 0);
        // R4: fixed-interval event then R6 interrupt one cycle later
        step("R4", 0, 0, 0, 0, 0, 0, 6'b000001);
        idle("R6");
        // R4: all watchdog and decrementer sets
        step("R4", 0, 0, 0, 0, 0, 0, 6'b111110);
        idle("R6");
        idle("R6");
        // R8: clear fixed-interval flag
        step("R8", 0, 0, 0, 1, 32'h0400_0000, 0, 0);
        idle("R8");
        // R8: clear of an already-clear flag still re-arms
        step("R8", 0, 0, 0, 1, 32'h0400_0000, 0, 0);
        // R5: watchdog set and clear same cycle
        step("R5", 0, 0, 0, 1, 32'h4000_0000, 0, 6'b010000);
        // R3: clear of unimplemented bits has no effect
        step("R3", 0, 0, 0, 1, 32'h03FF_FFFF, 0, 0);
        idle("R3");
        // R7: resume clears 31:28 only
        step("R7", 0, 0, 0, 0, 0, 1, 0);
        idle("R7");
        // R9: watchdog clear write re-arms
        step("R4", 0, 0, 0, 0, 0, 0, 6'b010001);
        step("R9", 0, 0, 0, 1, 32'h4000_0000, 0, 0);
        idle("R9");
        // R5: resume colliding with enable-next set
        step("R5", 0, 0, 0, 0, 0, 1, 6'b100000);
        idle("R5");
        // R6: disabling decrementer enable drops its line
        step("R6", 0, 1, 32'h0880_0000, 0, 0, 0, 0);
        idle("R6");
        idle("R6");
        // R3: clear all
        step("R3", 0, 0, 0, 1, 32'hFFFF_FFFF, 0, 0);
        idle("R3");
        // R10: control write of zero
        step("R10", 0, 1, 32'h0, 0, 0, 0, 0);
        // R1: mid-run reset
        step("R4", 0, 1, 32'hFFFF_FFFF, 0, 0, 0, 6'b111111);
        step("R1", 1, 0, 0, 0, 0, 0, 6'b111111);
        idle("R1");
        @(posedge clk);
        #3;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule